// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one display channel. Software writes the horizontal and vertical geometry, the sync placement, the sync polarities and a few enables through a small 32-bit register port. From these the block runs a horizontal pixel counter and a vertical line counter. It also drives horizontal and vertical sync, a display-active window and a plane-visible signal for the downstream pixel pipeline.

The total, display-end and sync-start fields hold the wanted value minus one. In the counter's zero-based terms, each field is the last count of its span or the first count of its sync. The sync width and height fields hold raw counts. Turning the plane on or off is deferred. A write is held pending until the counters reach the first pixel of the vertical sync start line, and until then the control register reads back the plane state that is in force. An optional output carries the pixel-clock edge select for a panel interface.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset both counters read zero, hsync and vsync are low, display-active, plane-visible and the clock phase output are low, and every register reads zero.
- R2: With timing enabled the horizontal counter counts up each clock and returns to 0 on the clock after it equals the horizontal total field. The vertical counter steps once on each horizontal return and returns to 0 after the step taken while it equals the vertical total field.
- R3: The horizontal sync is active while the horizontal count lies from the sync-start field to the sync-start field plus the raw width minus one. A width of zero never asserts it.
- R4: The vertical sync is active while the vertical count lies from its sync-start field to that field plus the raw height minus one. A height of zero never asserts it.
- R5: Control bit 2 sets horizontal sync polarity and control bit 3 sets vertical sync polarity: 0 makes the sync active high, 1 makes it active low.
- R6: Display-active is high exactly when timing is enabled, the horizontal count is at or below the horizontal display-end field and the vertical count is at or below the vertical display-end field.
- R7: Plane-visible equals display-active ANDed with the applied plane enable.
- R8: A write of control bit 1 (plane enable) is applied on the clock edge at which timing is enabled, the horizontal count is 0 and the vertical count equals the vertical sync-start field. Until then, control bit 1 reads back the previously applied value.
- R9: Control bit 0 is the timing enable. While it is clear, both counters are held at zero and both syncs sit at their inactive level.
- R10: Control bits 31 to 5 are ignored and read as zero. Control bit 4 drives the pixel clock phase output directly.
- R11: Address 0 holds horizontal total in bits [CW-1:0] and horizontal display-end in bits [16+CW-1:16]. Address 1 holds horizontal sync start low and width high. Address 2 holds vertical total low and display-end high. Address 3 holds vertical sync start low and height high. Address 4 is control. Addresses 5 to 7 read zero, and read data follows the address without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| h_count | output | CW | Horizontal pixel count |
| v_count | output | CW | Vertical line count |
| hsync | output | 1 | Horizontal sync, polarity per control bit 2 |
| vsync | output | 1 | Vertical sync, polarity per control bit 3 |
| disp_active | output | 1 | Inside the visible window with timing on |
| plane_vis | output | 1 | Display-active gated by the applied plane enable |
| pix_clk_phase | output | 1 | Pixel clock edge select |

## Verification
A small 10-by-6 raster is swept through every clock of several whole frames under all four polarity combinations. This separates active-high from active-low syncs and shows the exact first and last count of each sync and visible span. A second geometry uses a zero-width horizontal sync, a multi-line vertical sync starting on line 1, and a display-end beyond the total, which tells an empty window apart from a full one. Plane-enable writes are made mid-frame and read back on every clock until the vertical sync start line, so an immediate update and a deferred one give different results. Disabling timing mid-frame, writing reserved bits and reading unmapped addresses cover the hold, ignore and decode cases.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int unsigned DTG_DW     = 32;
   localparam int unsigned DTG_AW     = 3;
   localparam int unsigned DTG_HI_LSB = 16;

   localparam logic [DTG_AW-1:0] RA_HTIM = 3'd0;
   localparam logic [DTG_AW-1:0] RA_HSYN = 3'd1;
   localparam logic [DTG_AW-1:0] RA_VTIM = 3'd2;
   localparam logic [DTG_AW-1:0] RA_VSYN = 3'd3;
   localparam logic [DTG_AW-1:0] RA_CTRL = 3'd4;

   localparam int unsigned CB_TEN   = 0;
   localparam int unsigned CB_PLANE = 1;
   localparam int unsigned CB_HPOL  = 2;
   localparam int unsigned CB_VPOL  = 3;
   localparam int unsigned CB_CPH   = 4;

   typedef struct packed {
      logic cph;
      logic vpol;
      logic hpol;
      logic plane;
      logic ten;
   } dtg_ctrl_t;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis #(
   parameter int unsigned CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [CW-1:0] last,
   input  logic [CW-1:0] win_at,
   input  logic [CW-1:0] win_len,
   input  logic [CW-1:0] vis_last,
   output logic [CW-1:0] count,
   output logic          wrap,
   output logic          in_win,
   output logic          in_vis
);
   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q >= last);
   assign wrap   = run & step & at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assign in_win = (cnt_q >= win_at) && ((cnt_q - win_at) < win_len);
   assign in_vis = (cnt_q <= vis_last);
   assign count  = cnt_q;
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int unsigned CW            = 12,
   parameter bit          HAS_CLK_PHASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DTG_AW-1:0] addr,
   input  logic [DTG_DW-1:0] wdata,
   input  logic              apply,
   output logic [DTG_DW-1:0] rdata,
   output logic [CW-1:0]     htot,
   output logic [CW-1:0]     hde,
   output logic [CW-1:0]     hss,
   output logic [CW-1:0]     hsw,
   output logic [CW-1:0]     vtot,
   output logic [CW-1:0]     vde,
   output logic [CW-1:0]     vss,
   output logic [CW-1:0]     vsh,
   output dtg_ctrl_t         ctrl
);
   localparam int unsigned HI = DTG_HI_LSB;

   logic [CW-1:0] lo_f, hi_f;
   logic          plane_pend_q;
   dtg_ctrl_t     ctrl_q;
   dtg_ctrl_t     ctrl_rd;
   wire           unused_wbits = &{1'b0, wdata};

   assign lo_f = wdata[CW-1:0];
   assign hi_f = wdata[HI +: CW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         htot <= '0; hde <= '0; hss <= '0; hsw <= '0;
         vtot <= '0; vde <= '0; vss <= '0; vsh <= '0;
         ctrl_q       <= '0;
         plane_pend_q <= 1'b0;
      end else begin
         if (apply) ctrl_q.plane <= plane_pend_q;
         if (wr_en) begin
            case (addr)
               RA_HTIM: begin htot <= lo_f; hde <= hi_f; end
               RA_HSYN: begin hss  <= lo_f; hsw <= hi_f; end
               RA_VTIM: begin vtot <= lo_f; vde <= hi_f; end
               RA_VSYN: begin vss  <= lo_f; vsh <= hi_f; end
               RA_CTRL: begin
                  ctrl_q.ten   <= wdata[CB_TEN];
                  ctrl_q.hpol  <= wdata[CB_HPOL];
                  ctrl_q.vpol  <= wdata[CB_VPOL];
                  ctrl_q.cph   <= wdata[CB_CPH] & HAS_CLK_PHASE;
                  plane_pend_q <= wdata[CB_PLANE];
               end
               default: ;
            endcase
         end
      end
   end

   assign ctrl    = ctrl_q;
   assign ctrl_rd = ctrl_q;

   always_comb begin
      rdata = '0;
      case (addr)
         RA_HTIM: begin rdata[CW-1:0] = htot; rdata[HI +: CW] = hde; end
         RA_HSYN: begin rdata[CW-1:0] = hss;  rdata[HI +: CW] = hsw; end
         RA_VTIM: begin rdata[CW-1:0] = vtot; rdata[HI +: CW] = vde; end
         RA_VSYN: begin rdata[CW-1:0] = vss;  rdata[HI +: CW] = vsh; end
         RA_CTRL: rdata[$bits(dtg_ctrl_t)-1:0] = ctrl_rd;
         default: ;
      endcase
   end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import dtg_pkg::*;
#(
   parameter int unsigned CW            = 12,
   parameter bit          HAS_CLK_PHASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DTG_AW-1:0] addr,
   input  logic [DTG_DW-1:0] wdata,
   output logic [DTG_DW-1:0] rdata,
   output logic [CW-1:0]     h_count,
   output logic [CW-1:0]     v_count,
   output logic              hsync,
   output logic              vsync,
   output logic              disp_active,
   output logic              plane_vis,
   output logic              pix_clk_phase
);
   if (CW < 2 || CW > DTG_HI_LSB) begin : g_cw_bad
      $error("raster_timing_gen: CW must lie in 2..16");
   end

   logic [CW-1:0] htot_r, hde_r, hss_r, hsw_r, vtot_r, vde_r, vss_r, vsh_r;
   dtg_ctrl_t     ctrl_r;
   logic          h_wrap, v_wrap, h_win, v_win, h_vis, v_vis, apply;

   assign apply = ctrl_r.ten && (h_count == '0) && (v_count == vss_r);

   dtg_regs #(.CW(CW), .HAS_CLK_PHASE(HAS_CLK_PHASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .apply(apply), .rdata(rdata),
      .htot(htot_r), .hde(hde_r), .hss(hss_r), .hsw(hsw_r),
      .vtot(vtot_r), .vde(vde_r), .vss(vss_r), .vsh(vsh_r),
      .ctrl(ctrl_r)
   );

   dtg_axis #(.CW(CW)) u_hax (
      .clk(clk), .rst_n(rst_n), .run(ctrl_r.ten), .step(1'b1),
      .last(htot_r), .win_at(hss_r), .win_len(hsw_r), .vis_last(hde_r),
      .count(h_count), .wrap(h_wrap), .in_win(h_win), .in_vis(h_vis)
   );

   dtg_axis #(.CW(CW)) u_vax (
      .clk(clk), .rst_n(rst_n), .run(ctrl_r.ten), .step(h_wrap),
      .last(vtot_r), .win_at(vss_r), .win_len(vsh_r), .vis_last(vde_r),
      .count(v_count), .wrap(v_wrap), .in_win(v_win), .in_vis(v_vis)
   );

   assign hsync       = (ctrl_r.ten & h_win) ^ ctrl_r.hpol;
   assign vsync       = (ctrl_r.ten & v_win) ^ ctrl_r.vpol;
   assign disp_active = ctrl_r.ten & h_vis & v_vis;
   assign plane_vis   = disp_active & ctrl_r.plane;

   if (HAS_CLK_PHASE) begin : g_cph
      assign pix_clk_phase = ctrl_r.cph;
   end else begin : g_no_cph
      assign pix_clk_phase = 1'b0;
   end
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
   parameter int unsigned CW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] h,
   input logic [CW-1:0] v,
   input logic [CW-1:0] htot,
   input logic [CW-1:0] vss,
   input logic          ten,
   input logic          hpol,
   input logic          vpol,
   input logic          plane_app,
   input logic          v_wrap,
   input logic          hs,
   input logic          vs,
   input logic          disp,
   input logic          vis
);
   // R2
   h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h > htot) |=> (h == '0));
   // R2
   v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_wrap |=> (v == '0));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ten && !$past(ten)) |-> (h == '0 && v == '0));
   // R9
   idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ten |-> (hs == hpol && vs == vpol));
   // R6
   disp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp |-> ten);
   // R7
   vis_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vis |-> disp);
   // R8
   plane_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(plane_app) |-> $past(ten && h == '0 && v == vss));
endmodule

bind raster_timing_gen dtg_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .h(h_count), .v(v_count), .htot(htot_r),
   .vss(vss_r), .ten(ctrl_r.ten), .hpol(ctrl_r.hpol), .vpol(ctrl_r.vpol),
   .plane_app(ctrl_r.plane), .v_wrap(v_wrap), .hs(hsync), .vs(vsync),
   .disp(disp_active), .vis(plane_vis)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
   localparam time CLK_P = 10;
   localparam int  CW    = 12;
   localparam int  MSK   = (1 << CW) - 1;

   logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [2:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [CW-1:0] h_count, v_count;
   logic          hsync, vsync, disp_active, plane_vis, pix_clk_phase;

   int  vecs = 0, miss = 0;
   bit  done = 1'b0;
   int  m_h, m_v, m_ht, m_hde, m_hss, m_hsw, m_vt, m_vde, m_vss, m_vsh;
   bit  m_ten, m_hp, m_vp, m_cp, m_pend, m_app;

   always #(CLK_P/2) clk = ~clk;

   raster_timing_gen #(.CW(CW), .HAS_CLK_PHASE(1'b1)) u0 (.*);

   task automatic chk(string req, string what, longint act, longint exp);
      vecs++;
      if (act != exp) begin
         miss++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic longint exp_rd(int a);
      case (a)
         0: return m_ht  | (m_hde << 16);
         1: return m_hss | (m_hsw << 16);
         2: return m_vt  | (m_vde << 16);
         3: return m_vss | (m_vsh << 16);
         4: return {m_cp, m_vp, m_hp, m_app, m_ten};
         default: return 0;
      endcase
   endfunction

   task automatic check_outs();
      bit hs_a, vs_a, da;
      hs_a = m_ten && m_h >= m_hss && (m_h - m_hss) < m_hsw;
      vs_a = m_ten && m_v >= m_vss && (m_v - m_vss) < m_vsh;
      da   = m_ten && m_h <= m_hde && m_v <= m_vde;
      chk("R2/R9", "h_count", h_count, m_h);
      chk("R2/R9", "v_count", v_count, m_v);
      chk("R3/R5", "hsync", hsync, hs_a ^ m_hp);
      chk("R4/R5", "vsync", vsync, vs_a ^ m_vp);
      chk("R6", "disp_active", disp_active, da);
      chk("R7", "plane_vis", plane_vis, da && m_app);
      chk("R10", "pix_clk_phase", pix_clk_phase, m_cp);
   endtask

   task automatic tick();
      bit ap;
      int nh, nv;
      @(posedge clk);
      ap = m_ten && m_h == 0 && m_v == m_vss;
      if (!m_ten) begin nh = 0; nv = 0; end
      else if (m_h >= m_ht) begin nh = 0; nv = (m_v >= m_vt) ? 0 : m_v + 1; end
      else begin nh = m_h + 1; nv = m_v; end
      if (!rst_n) begin
         nh = 0; nv = 0; ap = 0;
      end
      if (ap) m_app = m_pend;
      if (rst_n && wr_en) begin
         case (addr)
            3'd0: begin m_ht  = wdata & MSK; m_hde = (wdata >> 16) & MSK; end
            3'd1: begin m_hss = wdata & MSK; m_hsw = (wdata >> 16) & MSK; end
            3'd2: begin m_vt  = wdata & MSK; m_vde = (wdata >> 16) & MSK; end
            3'd3: begin m_vss = wdata & MSK; m_vsh = (wdata >> 16) & MSK; end
            3'd4: begin
               m_ten = wdata[0]; m_pend = wdata[1]; m_hp = wdata[2];
               m_vp = wdata[3]; m_cp = wdata[4];
            end
            default: ;
         endcase
      end
      m_h = nh; m_v = nv;
      @(negedge clk);
      check_outs();
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic wr(int a, logic [31:0] d);
      addr = a[2:0]; wdata = d; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, string req);
      addr = a[2:0];
      #1;
      chk(req, "rdata", rdata, exp_rd(a));
   endtask

   initial begin
      m_h = 0; m_v = 0; m_ht = 0; m_hde = 0; m_hss = 0; m_hsw = 0;
      m_vt = 0; m_vde = 0; m_vss = 0; m_vsh = 0;
      m_ten = 0; m_hp = 0; m_vp = 0; m_cp = 0; m_pend = 0; m_app = 0;
      run(3);
      // R1: reset state at ports and on every address
      for (int a = 0; a < 8; a++) rd(a, "R1");
      rst_n = 1'b1;
      run(2);
      // R11: geometry A, 10 x 6 raster
      wr(0, (5 << 16) | 9);
      wr(1, (2 << 16) | 7);
      wr(2, (3 << 16) | 5);
      wr(3, (1 << 16) | 4);
      for (int a = 0; a < 4; a++) rd(a, "R11");
      // R5/R8: all polarity pairs with plane on, lag checked every clock
      for (int p = 0; p < 4; p++) begin
         wr(4, 32'h3 | (p << 2));
         for (int i = 0; i < 130; i++) begin
            rd(4, "R8");
            tick();
         end
      end
      // R8: turn plane off mid-frame, read back lags until vsync start line
      run(17);
      wr(4, 32'h1);
      for (int i = 0; i < 70; i++) begin
         rd(4, "R8");
         tick();
      end
      // R3/R4/R6: geometry B, zero-width hsync, 3-line vsync, wide display end
      wr(0, (8 << 16) | 6);
      wr(1, (0 << 16) | 3);
      wr(2, (0 << 16) | 3);
      wr(3, (3 << 16) | 1);
      wr(4, 32'h3);
      for (int i = 0; i < 80; i++) begin
         rd(4, "R8");
         tick();
      end
      // R10: reserved bits ignored, clock phase bit brought out
      wr(4, 32'hFFFF_FFE0 | 32'h13);
      rd(4, "R10");
      run(40);
      // R9: timing off mid-frame, plane write held while idle
      run(5);
      wr(4, 32'h0);
      run(10);
      wr(4, 32'h2);
      for (int i = 0; i < 20; i++) begin
         rd(4, "R9");
         tick();
      end
      // R11: unmapped addresses
      for (int a = 5; a < 8; a++) rd(a, "R11");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         miss++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
         $finish;
      end
   end
endmodule